// File: doc/BRIEF.md
# Logical-Device DMA Channel and Interrupt Router

This block sits between four peripheral logical devices and a shared legacy I/O bus. The devices are a floppy controller (device 0), a parallel port (device 1) and two serial ports (devices 2 and 3). The bus side has four DMA request/acknowledge channels and one interrupt line per device. Software reaches the configuration through an index/data port pair. It first picks a logical device, then writes that device's activate bit and its 3-bit DMA channel-select code. Each device reports its own local enable conditions to the block as plain input levels: its DMA enable bit, power-down state, port mode, OUT2 bit and interrupt-enable bit. The decoder that validates each device's base address supplies one flag per device.

A device owns a channel only when three things hold at once: its select code names a real channel, the device is activated with a valid base address, and its own local DMA condition is true. The block forwards the owning device's request to that channel and returns the channel's acknowledge to that device alone. A channel that no device owns is not driven: its output enable is low, which stands in for a floating pin. If two live devices pick the same channel, the lower-numbered device wins and a conflict flag is raised. Interrupts pass through under the same style of gating, and a disabled interrupt floats.

Top module: `ldev_dma_irq_router`

## Requirements
- R1: Address 0 is the index port and reads back the last index written. Address 1 is the data port for the register named by the index. Index 0x07 holds the selected device number in bits [1:0]. Index 0x30 holds that device's activate bit in bit 0. Index 0x74 holds that device's channel-select code. Any other index reads 0x00.
- R2: A write to index 0x74 stores only data bits [2:0]. A read returns the code in bits [2:0], with bits [7:3] as zero.
- R3: After reset every select code is 4, every activate bit is 0, and the index and device number are 0. No request output is enabled.
- R4: Codes 0 to 3 map a device to channels 0 to 3. Codes 4 to 7 give the device no channel.
- R5: The floppy device owns its channel only while fdc_dma_en is 1 and fdc_pwrdn is 0.
- R6: The parallel port owns its channel only while pp_ecp_mode is 1 and pp_ecr_dma_en is 1. Device 3 owns its channel only while sp2_dma_en is 1. Device 2 never owns a channel.
- R7: A channel with no owner has chan_drq_oe low and chan_drq low. An owned channel has chan_drq_oe high and carries the owner's dev_drq.
- R8: While fdc_pwrdn is 1 or fdc_dma_en is 0, irq_oe[0] and dev_dack[0] are 0.
- R9: irq_oe[2] follows sp_out2[0], and irq_oe[3] follows sp_out2[1].
- R10: When pp_ecp_mode is 0, irq_oe[1] follows pp_irq_en. When pp_ecp_mode is 1, the interrupt is enabled.
- R11: A device whose activate bit is 0, or whose dev_base_ok bit is 0, has no channel, no interrupt enable and no acknowledge.
- R12: When several live devices select one channel, the lowest-numbered device owns it and chan_conflict is 1. The losing devices get no acknowledge.
- R13: dev_dack[d] equals chan_dack[c] when device d owns channel c, and is 0 otherwise. irq_out[d] equals dev_irq[d] while irq_oe[d] is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for the addressed port |
| dev_base_ok | input | 4 | Per-device flag: base address is valid |
| fdc_dma_en | input | 1 | Floppy DMA enable bit |
| fdc_pwrdn | input | 1 | Floppy is powered down |
| pp_ecp_mode | input | 1 | Parallel port is in ECP mode |
| pp_ecr_dma_en | input | 1 | Parallel port DMA enable bit in ECP mode |
| pp_irq_en | input | 1 | Parallel port interrupt enable bit in SPP/EPP mode |
| sp_out2 | input | 2 | OUT2 bit of each serial port |
| sp2_dma_en | input | 1 | DMA enable of the second serial port |
| dev_drq | input | 4 | DMA request from each device |
| dev_irq | input | 4 | Interrupt from each device |
| chan_dack | input | 4 | Acknowledge on each bus channel |
| chan_drq | output | 4 | Request value on each bus channel |
| chan_drq_oe | output | 4 | Output enable of each channel request |
| dev_dack | output | 4 | Acknowledge routed to each device |
| irq_out | output | 4 | Interrupt value for each device |
| irq_oe | output | 4 | Output enable of each device interrupt |
| chan_conflict | output | 1 | Two or more live devices select one channel |

## Verification
The bench puts the floppy and the parallel port on the same channel. The floppy must win that channel and the flag must rise. A design with the priority reversed would route the parallel port's request and acknowledge instead. The bench also covers channels that lose their owner to a cleared enable, an invalid select code or a cleared activate bit, and checks that their enables drop rather than drive low. It writes a select value with high bits set to confirm that only three bits are stored. It parks the parallel port in each of its modes to check that its interrupt and DMA gating follow the mode.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    localparam int NDEV  = 4;
    localparam int NCH   = 4;
    localparam int SELW  = 3;
    localparam int DEVW  = $clog2(NDEV);
    localparam int IDXW  = 8;

    localparam logic [IDXW-1:0] IDX_LDN = 8'h07;
    localparam logic [IDXW-1:0] IDX_ACT = 8'h30;
    localparam logic [IDXW-1:0] IDX_SEL = 8'h74;
    localparam logic [SELW-1:0] SEL_NONE = 3'd4;

    typedef enum logic [DEVW-1:0] {
        DEV_FDC = 2'd0,
        DEV_PP  = 2'd1,
        DEV_SPA = 2'd2,
        DEV_SPB = 2'd3
    } dev_id_e;

    typedef struct packed {
        logic [IDXW-1:0]            index;
        logic [DEVW-1:0]            ldn;
        logic [NDEV-1:0][SELW-1:0]  sel;
        logic [NDEV-1:0]            act;
    } cfg_state_t;
endpackage

// File: rtl/ldr_cfg_regs.sv
module ldr_cfg_regs
    import ldr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       cfg_addr,
    input  logic [IDXW-1:0]            cfg_wdata,
    output logic [IDXW-1:0]            cfg_rdata,
    output logic [NDEV-1:0][SELW-1:0]  sel_codes,
    output logic [NDEV-1:0]            act_bits
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (!cfg_addr) begin
                st_d.index = cfg_wdata;
            end else begin
                unique case (st_q.index)
                    IDX_LDN: st_d.ldn = cfg_wdata[DEVW-1:0];
                    IDX_ACT: st_d.act[st_q.ldn] = cfg_wdata[0];
                    IDX_SEL: st_d.sel[st_q.ldn] = cfg_wdata[SELW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.index <= '0;
            st_q.ldn   <= '0;
            st_q.act   <= '0;
            for (int d = 0; d < NDEV; d++) st_q.sel[d] <= SEL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (!cfg_addr) begin
            cfg_rdata = st_q.index;
        end else begin
            case (st_q.index)
                IDX_LDN: cfg_rdata[DEVW-1:0] = st_q.ldn;
                IDX_ACT: cfg_rdata[0]        = st_q.act[st_q.ldn];
                IDX_SEL: cfg_rdata[SELW-1:0] = st_q.sel[st_q.ldn];
                default: cfg_rdata = '0;
            endcase
        end
    end

    assign sel_codes = st_q.sel;
    assign act_bits  = st_q.act;

    // R2: a select write stores exactly three bits for the addressed device
    p_sel_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr && st_q.index == IDX_SEL)
        |=> st_q.sel[$past(st_q.ldn)] == $past(cfg_wdata[SELW-1:0]));

    // R1: index port writes land in the index register
    p_index_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_addr) |=> st_q.index == $past(cfg_wdata));
endmodule

// File: rtl/ldr_dev_gate.sv
module ldr_dev_gate
    import ldr_pkg::*;
(
    input  logic [NDEV-1:0][SELW-1:0]  sel_codes,
    input  logic [NDEV-1:0]            act_bits,
    input  logic [NDEV-1:0]            base_ok,
    input  logic                       fdc_dma_en,
    input  logic                       fdc_pwrdn,
    input  logic                       pp_ecp_mode,
    input  logic                       pp_ecr_dma_en,
    input  logic                       pp_irq_en,
    input  logic [1:0]                 sp_out2,
    input  logic                       sp2_dma_en,
    output logic [NDEV-1:0]            dma_live,
    output logic [NDEV-1:0]            irq_live
);
    logic [NDEV-1:0] present;
    logic [NDEV-1:0] code_ok;
    logic [NDEV-1:0] local_dma;
    logic [NDEV-1:0] local_irq;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        assign present[d] = act_bits[d] & base_ok[d];
        assign code_ok[d] = (sel_codes[d] < SELW'(NCH));
    end

    always_comb begin
        local_dma = '0;
        local_irq = '0;
        local_dma[DEV_FDC] = fdc_dma_en & ~fdc_pwrdn;
        local_irq[DEV_FDC] = fdc_dma_en & ~fdc_pwrdn;
        local_dma[DEV_PP]  = pp_ecp_mode & pp_ecr_dma_en;
        local_irq[DEV_PP]  = pp_ecp_mode | pp_irq_en;
        local_dma[DEV_SPA] = 1'b0;
        local_irq[DEV_SPA] = sp_out2[0];
        local_dma[DEV_SPB] = sp2_dma_en;
        local_irq[DEV_SPB] = sp_out2[1];
    end

    assign dma_live = present & code_ok & local_dma;
    assign irq_live = present & local_irq;
endmodule

// File: rtl/ldr_chan_arb.sv
module ldr_chan_arb
    import ldr_pkg::*;
(
    input  logic [NDEV-1:0]            dma_live,
    input  logic [NDEV-1:0][SELW-1:0]  sel_codes,
    input  logic [NDEV-1:0]            dev_drq,
    input  logic [NCH-1:0]             chan_dack,
    output logic [NCH-1:0]             chan_drq,
    output logic [NCH-1:0]             chan_drq_oe,
    output logic [NDEV-1:0]            dev_dack,
    output logic                       conflict
);
    logic [NCH-1:0][NDEV-1:0] want;
    logic [NCH-1:0][NDEV-1:0] win;
    logic [NCH-1:0]           multi;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar d = 0; d < NDEV; d++) begin : g_req
            assign want[c][d] = dma_live[d] && (sel_codes[d] == SELW'(c));
        end

        always_comb begin
            win[c] = '0;
            for (int d = NDEV - 1; d >= 0; d--) begin
                if (want[c][d]) win[c] = NDEV'(1) << d;
            end
        end

        assign chan_drq_oe[c] = |want[c];
        assign chan_drq[c]    = |(win[c] & dev_drq);
        assign multi[c]       = ($countones(want[c]) > 1);
    end

    always_comb begin
        dev_dack = '0;
        for (int d = 0; d < NDEV; d++) begin
            for (int c = 0; c < NCH; c++) begin
                if (win[c][d] && chan_dack[c]) dev_dack[d] = 1'b1;
            end
        end
    end

    assign conflict = |multi;
endmodule

// File: rtl/ldev_dma_irq_router.sv
module ldev_dma_irq_router
    import ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [3:0]        dev_base_ok,
    input  logic              fdc_dma_en,
    input  logic              fdc_pwrdn,
    input  logic              pp_ecp_mode,
    input  logic              pp_ecr_dma_en,
    input  logic              pp_irq_en,
    input  logic [1:0]        sp_out2,
    input  logic              sp2_dma_en,
    input  logic [3:0]        dev_drq,
    input  logic [3:0]        dev_irq,
    input  logic [3:0]        chan_dack,
    output logic [3:0]        chan_drq,
    output logic [3:0]        chan_drq_oe,
    output logic [3:0]        dev_dack,
    output logic [3:0]        irq_out,
    output logic [3:0]        irq_oe,
    output logic              chan_conflict
);
    logic [NDEV-1:0][SELW-1:0] sel_codes;
    logic [NDEV-1:0]           act_bits;
    logic [NDEV-1:0]           dma_live;
    logic [NDEV-1:0]           irq_live;

    ldr_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sel_codes (sel_codes),
        .act_bits  (act_bits)
    );

    ldr_dev_gate u_gate (
        .sel_codes     (sel_codes),
        .act_bits      (act_bits),
        .base_ok       (dev_base_ok),
        .fdc_dma_en    (fdc_dma_en),
        .fdc_pwrdn     (fdc_pwrdn),
        .pp_ecp_mode   (pp_ecp_mode),
        .pp_ecr_dma_en (pp_ecr_dma_en),
        .pp_irq_en     (pp_irq_en),
        .sp_out2       (sp_out2),
        .sp2_dma_en    (sp2_dma_en),
        .dma_live      (dma_live),
        .irq_live      (irq_live)
    );

    ldr_chan_arb u_arb (
        .dma_live    (dma_live),
        .sel_codes   (sel_codes),
        .dev_drq     (dev_drq),
        .chan_dack   (chan_dack),
        .chan_drq    (chan_drq),
        .chan_drq_oe (chan_drq_oe),
        .dev_dack    (dev_dack),
        .conflict    (chan_conflict)
    );

    assign irq_oe  = irq_live;
    assign irq_out = dev_irq & irq_live;

    // R8: a powered-down or DMA-disabled floppy neither interrupts nor sees acks
    p_fdc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fdc_pwrdn || !fdc_dma_en) |-> (!irq_oe[0] && !dev_dack[0]));

    // R9: serial interrupts float whenever OUT2 is clear
    p_out2_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_out2[0] |-> !irq_oe[2]) and (!sp_out2[1] |-> !irq_oe[3]));

    // R10: SPP/EPP parallel interrupt needs its enable bit
    p_pp_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pp_ecp_mode && !pp_irq_en) |-> !irq_oe[1]);

    // R11: an inactive device is fully cut off
    p_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_bits[0] && dev_base_ok[0]) |-> (!irq_oe[0] && !dev_dack[0]));

    // R7: a driven channel always has a live device choosing it
    p_oe_has_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_drq_oe[2] |-> ((dma_live[0] && sel_codes[0] == 3'd2) ||
                            (dma_live[1] && sel_codes[1] == 3'd2) ||
                            (dma_live[3] && sel_codes[3] == 3'd2)));

    // R13: an acknowledged device holds a driven channel that is acked
    p_dack_owner_r13: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dack[3] |-> (sel_codes[3] < 3'd4 && chan_drq_oe[sel_codes[3][1:0]]
                         && chan_dack[sel_codes[3][1:0]]));

    // R6: the first serial port never drives a channel of its own
    p_spa_no_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_dack[2]);
endmodule

// File: tb/sim_ldev_dma_irq_router.sv
module sim_ldev_dma_irq_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic [3:0] dev_base_ok = 4'hF;
    logic fdc_dma_en = 0, fdc_pwrdn = 0, pp_ecp_mode = 0, pp_ecr_dma_en = 0, pp_irq_en = 0;
    logic [1:0] sp_out2 = '0;
    logic sp2_dma_en = 0;
    logic [3:0] dev_drq = '0, dev_irq = 4'hF, chan_dack = '0;
    logic [3:0] chan_drq, chan_drq_oe, dev_dack, irq_out, irq_oe;
    logic chan_conflict;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ldev_dma_irq_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_base_ok(dev_base_ok),
        .fdc_dma_en(fdc_dma_en), .fdc_pwrdn(fdc_pwrdn), .pp_ecp_mode(pp_ecp_mode),
        .pp_ecr_dma_en(pp_ecr_dma_en), .pp_irq_en(pp_irq_en), .sp_out2(sp_out2),
        .sp2_dma_en(sp2_dma_en), .dev_drq(dev_drq), .dev_irq(dev_irq),
        .chan_dack(chan_dack), .chan_drq(chan_drq), .chan_drq_oe(chan_drq_oe),
        .dev_dack(dev_dack), .irq_out(irq_out), .irq_oe(irq_oe),
        .chan_conflict(chan_conflict)
    );

    // ctl bits: [7] fdc_dma_en [6] fdc_pwrdn [5] pp_ecp_mode [4] pp_ecr_dma_en
    //           [3] pp_irq_en [2:1] sp_out2 [0] sp2_dma_en
    typedef struct packed {
        logic [7:0] ctl;
        logic [3:0] drq;
        logic [3:0] dack;
        logic [3:0] e_oe;
        logic [3:0] e_drq;
        logic [3:0] e_dk;
        logic [3:0] e_irq;
        logic       e_cf;
    } vec_t;

    // select codes: dev0=2, dev1=2, dev2=0, dev3=1; all active, all bases valid
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'b1011_0111, 4'b1111, 4'b0110, 4'b0110, 4'b0110, 4'b1001, 4'b1111, 1'b1},
        '{8'b0011_0111, 4'b1110, 4'b0100, 4'b0110, 4'b0110, 4'b0010, 4'b1110, 1'b0},
        '{8'b1100_1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0110, 1'b0},
        '{8'b1000_0101, 4'b0000, 4'b0010, 4'b0110, 4'b0000, 4'b1000, 4'b1001, 1'b0},
        '{8'b1010_0000, 4'b0001, 4'b0100, 4'b0100, 4'b0100, 4'b0001, 4'b0011, 1'b0},
        '{8'b0000_0000, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_reg(input logic [1:0] dev, input logic [7:0] idx, input logic [7:0] val);
        wr(1'b0, 8'h07); wr(1'b1, {6'd0, dev});
        wr(1'b0, idx);   wr(1'b1, val);
    endtask

    task automatic apply_ctl(input logic [7:0] c);
        {fdc_dma_en, fdc_pwrdn, pp_ecp_mode, pp_ecr_dma_en, pp_irq_en, sp_out2, sp2_dma_en} = c;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        for (int d = 0; d < 4; d++) begin
            wr(1'b0, 8'h07); wr(1'b1, 8'(d)); wr(1'b0, 8'h74);
            rd(1'b1, r); check("R3 sel reset", r, 8'h04);
        end
        wr(1'b0, 8'h30); rd(1'b1, r); check("R3 act reset", r, 8'h00);
        apply_ctl(8'b1011_0111); dev_drq = 4'hF;
        #1 check("R3 no channel after reset", {4'd0, chan_drq_oe}, 8'h00);

        // R1: index readback and unlisted index
        wr(1'b0, 8'h5A); rd(1'b0, r); check("R1 index readback", r, 8'h5A);
        rd(1'b1, r); check("R1 unlisted index", r, 8'h00);

        // R2: only three bits stored
        set_reg(2'd1, 8'h74, 8'hFA); rd(1'b1, r); check("R2 sel width", r, 8'h02);

        // configure for the vector table
        for (int d = 0; d < 4; d++) set_reg(2'(d), 8'h30, 8'h01);
        set_reg(2'd0, 8'h74, 8'h02);
        set_reg(2'd1, 8'h74, 8'h02);
        set_reg(2'd2, 8'h74, 8'h00);
        set_reg(2'd3, 8'h74, 8'h01);
        rd(1'b1, r); check("R1 sel readback dev3", r, 8'h01);
        wr(1'b0, 8'h30); rd(1'b1, r); check("R1 act readback", r, 8'h01);

        // R4 R5 R6 R7 R8 R9 R10 R12 R13: vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply_ctl(VECS[i].ctl); dev_drq = VECS[i].drq; chan_dack = VECS[i].dack;
            #2;
            check("R7 drq_oe", {4'd0, chan_drq_oe}, {4'd0, VECS[i].e_oe});
            check("R7 drq value", {4'd0, chan_drq}, {4'd0, VECS[i].e_drq});
            check("R13 dack route", {4'd0, dev_dack}, {4'd0, VECS[i].e_dk});
            check("R9 R10 irq_oe", {4'd0, irq_oe}, {4'd0, VECS[i].e_irq});
            check("R13 irq value", {4'd0, irq_out}, {4'd0, VECS[i].e_irq});
            check("R12 conflict", {7'd0, chan_conflict}, {7'd0, VECS[i].e_cf});
        end

        // R4: code 6 on device 3 frees channel 1
        set_reg(2'd3, 8'h74, 8'h06);
        @(negedge clk); apply_ctl(8'b1011_0111); dev_drq = 4'hF; chan_dack = 4'hF;
        #2 check("R4 code 6 no channel", {4'd0, chan_drq_oe}, 8'h04);
        check("R4 no dack on code 6", {7'd0, dev_dack[3]}, 8'h00);

        // R13: device 3 on channel 3 gets only that ack
        set_reg(2'd3, 8'h74, 8'h03);
        @(negedge clk); chan_dack = 4'b1000; dev_drq = 4'b1000;
        #2 check("R13 ch3 dack", {4'd0, dev_dack}, 8'h08);
        check("R13 ch3 drq", {4'd0, chan_drq}, 8'h08);

        // R11: floppy deactivated hands channel 2 to the parallel port
        set_reg(2'd0, 8'h30, 8'h00);
        @(negedge clk); chan_dack = 4'b0100; dev_drq = 4'b0010;
        #2 check("R11 inactive irq", {7'd0, irq_oe[0]}, 8'h00);
        check("R11 pp takes ch2 dack", {4'd0, dev_dack}, 8'h02);
        check("R11 pp drives ch2", {4'd0, chan_drq}, 8'h04);
        check("R12 conflict clears", {7'd0, chan_conflict}, 8'h00);

        // R11: invalid base on device 3
        @(negedge clk); dev_base_ok = 4'b0111; chan_dack = 4'b1000;
        #2 check("R11 base invalid drq_oe", {7'd0, chan_drq_oe[3]}, 8'h00);
        check("R11 base invalid irq", {7'd0, irq_oe[3]}, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule